// File: doc/BRIEF.md
# Self-Configuring Six-Face Lookup Cell

This block is one cell of a three-dimensional reconfigurable array. The cell has six faces, each with one data bit and one control bit in each direction. In normal operation the six incoming data bits form a row address into a 64-row truth table. The twelve bits stored in the selected row drive every face's outgoing data and control bits directly, with no register in the path.

When any incoming control bit is high, the cell stops evaluating and becomes a serial shift register over its whole table. It moves one bit per rising clock edge, and a full rewrite takes 768 edges. The bit about to leave the table is shown on the data output of each requesting face. A neighbour can therefore read the old configuration while it writes a new one.

Because a cell's outputs can be wired to an adjacent cell's inputs, one configured cell can route a configuration stream into its neighbour. No dedicated programming port is needed. Two cells wired in a loop can hold state, for example as a level-sensitive latch.

Top module: `lut_cell3d`

## Requirements
- R1: After reset the whole table is zero, so in normal mode every data and control output reads 0 for every address.
- R2: In normal mode, address bit f is the data input of face f, with faces numbered 0 to 5 as +X, -X, +Y, -Y, +Z, -Z. Bit 2f of the selected 12-bit row drives the data output of face f, and bit 2f+1 drives its control output. The outputs follow the inputs combinationally.
- R3: While any control input is high, the table shifts by one bit on each rising clock edge. Flat bit position is row*12+bit. After exactly 768 edges, the first bit presented sits at row 0 bit 0 and the last sits at row 63 bit 11.
- R4: While shifting, the data output of every face whose control input is high shows the bit that the next edge pushes out. Over 768 edges the old table emerges in the order row 0 bit 0 first, row 63 bit 11 last.
- R5: When several control inputs are high, the incoming bit is taken from the active face with the lowest number.
- R6: While shifting, all control outputs are 0, and so are the data outputs of faces whose control input is low.
- R7: With every control input low, the table keeps its contents whatever the data inputs do.
- R8: A cell whose table routes two of its data inputs to the control and data outputs of a face can program the neighbour on that face. It also returns the neighbour's old contents.
- R9: Two cells wired in a loop, one holding Q = LOAD ? D : Q and the other a buffer, act as a latch. The output follows D while LOAD is 1 and keeps the last D after LOAD falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for table shifting |
| rst_n | input | 1 | Asynchronous active-low reset, clears the table |
| data_in | input | NUM_FACES | Incoming data bit per face, row address in normal mode |
| ctrl_in | input | NUM_FACES | Incoming control bit per face, any high selects shifting |
| data_out | output | NUM_FACES | Outgoing data bit per face |
| ctrl_out | output | NUM_FACES | Outgoing control bit per face |

## Verification
The bench builds two cells with the default of six faces: 64 rows, 12-bit rows and a 768-bit stream. This makes every full rewrite short enough to repeat five times. Each rewrite's readback then checks the complete previous table bit by bit, including the zeros left by reset and a table written with two faces requesting at once. The second cell, behind the first one's -X face, brings neighbour programming through a routing table within reach, as well as the feedback latch.

// File: rtl/lut_cell3d.sv
module lut_cell3d #(
  parameter int NUM_FACES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FACES-1:0] data_in,
  input  logic [NUM_FACES-1:0] ctrl_in,
  output logic [NUM_FACES-1:0] data_out,
  output logic [NUM_FACES-1:0] ctrl_out
);
  localparam int ROWS     = 1 << NUM_FACES;
  localparam int ROW_W    = 2 * NUM_FACES;
  localparam int CFG_BITS = ROWS * ROW_W;
  localparam int IDX_W    = $clog2(CFG_BITS);

  logic [CFG_BITS-1:0] tbl;
  logic [IDX_W-1:0]    row_base;
  logic [ROW_W-1:0]    row;
  logic                cfg_mode;
  logic                ser_bit;

  assign cfg_mode = |ctrl_in;
  assign row_base = IDX_W'(data_in) * IDX_W'(ROW_W);
  assign row      = tbl[row_base +: ROW_W];

  always_comb begin
    ser_bit = 1'b0;
    for (int f = NUM_FACES - 1; f >= 0; f--)
      if (ctrl_in[f]) ser_bit = data_in[f];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        tbl <= '0;
    else if (cfg_mode) tbl <= {ser_bit, tbl[CFG_BITS-1:1]};

  for (genvar f = 0; f < NUM_FACES; f++) begin : g_face
    assign data_out[f] = cfg_mode ? (ctrl_in[f] & tbl[0]) : row[2*f];
    assign ctrl_out[f] = cfg_mode ? 1'b0 : row[2*f+1];
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (tbl == '0));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |=> (tbl[CFG_BITS-2:0] == $past(tbl[CFG_BITS-1:1])));

  assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> ((data_out & ctrl_in) == (ctrl_in & {NUM_FACES{tbl[0]}})));

  assert_first_face_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_in[0] |=> (tbl[CFG_BITS-1] == $past(data_in[0])));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> (ctrl_out == '0 && (data_out & ~ctrl_in) == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(tbl));
endmodule

// File: tb/lut_cell3d_bench.sv
`timescale 1ns/1ps
module lut_cell3d_bench;
  localparam int CFG = 768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic use_fb = 1'b0;
  logic fb_q = 1'b0;
  logic [5:0] drv_din = '0, drv_cin = '0;
  logic [5:0] top_din, top_cin, top_dout, top_cout;
  logic [5:0] peer_din, peer_cin, peer_dout, peer_cout;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign top_din  = use_fb ? {drv_din[5:2], fb_q, drv_din[0]} : drv_din;
  assign top_cin  = use_fb ? {drv_cin[5:2], peer_cout[0], drv_cin[0]} : drv_cin;
  assign peer_din = use_fb ? {5'b0, top_dout[1]} : 6'b0;
  assign peer_cin = use_fb ? {5'b0, top_cout[1]} : 6'b0;
  always @(peer_dout) fb_q <= #1 peer_dout[0];

  lut_cell3d u_lut_cell3d (.clk(clk), .rst_n(rst_n), .data_in(top_din), .ctrl_in(top_cin),
                           .data_out(top_dout), .ctrl_out(top_cout));
  lut_cell3d u_peer (.clk(clk), .rst_n(rst_n), .data_in(peer_din), .ctrl_in(peer_cin),
                     .data_out(peer_dout), .ctrl_out(peer_cout));

  // address -> expected row word for the table {~addr, addr}
  localparam logic [17:0] VEC [8] = '{
    {6'h00, 12'hFC0}, {6'h3F, 12'h03F}, {6'h15, 12'hA95}, {6'h2A, 12'h56A},
    {6'h01, 12'hF81}, {6'h20, 12'h7E0}, {6'h0C, 12'hCCC}, {6'h33, 12'h333}};

  function automatic logic [11:0] word_of(input logic [5:0] d, input logic [5:0] c);
    for (int f = 0; f < 6; f++) begin
      word_of[2*f] = d[f];
      word_of[2*f+1] = c[f];
    end
  endfunction

  function automatic logic [CFG-1:0] fn_tab();
    for (int r = 0; r < 64; r++) fn_tab[r*12 +: 12] = {~6'(r), 6'(r)};
  endfunction

  function automatic logic [CFG-1:0] pat_tab(input bit inv);
    for (int k = 0; k < CFG; k++) pat_tab[k] = (((k * 5 + k / 7) % 3) == 0) ^ inv;
  endfunction

  function automatic logic [CFG-1:0] route_tab();
    route_tab = '0;
    for (int r = 0; r < 64; r++) begin
      route_tab[r*12 + 0] = r[1];
      route_tab[r*12 + 2] = r[2];
      route_tab[r*12 + 3] = r[3];
    end
  endfunction

  function automatic logic [CFG-1:0] buf_tab();
    buf_tab = '0;
    for (int r = 0; r < 64; r++) buf_tab[r*12] = r[0];
  endfunction

  function automatic logic [CFG-1:0] latch_tab();
    latch_tab = '0;
    for (int r = 0; r < 64; r++) begin
      latch_tab[r*12 + 0] = r[3] ? r[2] : r[1];
      latch_tab[r*12 + 2] = r[3] ? r[2] : r[1];
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic stream(input int cf, input int df, input int cf2, input int df2,
                        input logic [CFG-1:0] a, input logic [CFG-1:0] b,
                        input int rbf, input logic [CFG-1:0] old, input string req);
    int bad = 0;
    int dual_bad = 0;
    for (int k = 0; k < CFG; k++) begin
      @(negedge clk);
      if (cf >= 0) drv_cin[cf] = 1'b1;
      if (cf2 >= 0) drv_cin[cf2] = 1'b1;
      drv_din[df] = a[k];
      if (df2 >= 0) drv_din[df2] = b[k];
      #2;
      if (top_dout[rbf] !== old[k]) bad++;
      if (cf2 >= 0 && top_dout[cf2] !== top_dout[cf]) dual_bad++;
      if (k == 100 && cf >= 0)
        check(top_cout == 6'h0 && (top_dout & ~top_cin) == 6'h0, "R6 outputs quiet while shifting",
              {20'h0, top_cout, top_dout & ~top_cin}, 32'h0);
    end
    @(negedge clk);
    drv_cin = '0;
    drv_din = '0;
    check(bad == 0, req, bad, 0);
    if (cf2 >= 0) check(dual_bad == 0, "R5 both requesting faces show readback", dual_bad, 0);
  endtask

  task automatic eval_word(input logic [5:0] addr, input logic [11:0] exp, input string req);
    @(negedge clk);
    drv_din = addr;
    #2;
    check(word_of(top_dout, top_cout) == exp, req, word_of(top_dout, top_cout), exp);
  endtask

  task automatic latch_step(input bit load, input bit d, input bit exp, input string req);
    @(negedge clk);
    drv_din[3] = load;
    drv_din[2] = d;
    #5;
    check(top_dout[0] === exp, req, top_dout[0], exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CFG-1:0] p0, p1;
    p0 = pat_tab(1'b0);
    p1 = pat_tab(1'b1);
    drv_din = 6'h2B;
    repeat (3) @(negedge clk);
    #2;
    check(top_dout == 0 && top_cout == 0, "R1 outputs zero in reset", {top_dout, top_cout}, 0);
    rst_n = 1'b1;
    eval_word(6'h00, 12'h000, "R1 row 0 zero after reset");
    eval_word(6'h3F, 12'h000, "R1 row 63 zero after reset");
    eval_word(6'h16, 12'h000, "R1 row 22 zero after reset");

    // R3/R4: write {~a,a}, reading back the reset zeros
    stream(0, 0, -1, -1, fn_tab(), '0, 0, '0, "R4 readback of cleared table");
    for (int i = 0; i < 8; i++)
      eval_word(VEC[i][17:12], VEC[i][11:0], "R2 R3 row evaluation after write");

    // R7: data inputs wander with no control request
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      drv_din = 6'(i * 13);
    end
    eval_word(6'h15, 12'hA95, "R7 table held with controls low");
    eval_word(6'h33, 12'h333, "R7 table held with controls low");

    // R5: faces 0 and 2 both request, face 0 must win
    stream(0, 0, 2, 2, p0, p1, 0, fn_tab(), "R4 readback of previous table");
    eval_word(6'h00, p0[0 +: 12], "R5 lowest face data stored row 0");
    eval_word(6'h3F, p0[63*12 +: 12], "R5 lowest face data stored row 63");
    eval_word(6'h09, p0[9*12 +: 12], "R5 lowest face data stored row 9");

    stream(0, 0, -1, -1, route_tab(), '0, 0, p0, "R5 full table came from face 0");

    // R8: program the neighbour through the routing table
    use_fb = 1'b1;
    @(negedge clk);
    drv_din[3] = 1'b1;
    stream(-1, 2, -1, -1, buf_tab(), '0, 0, '0, "R8 neighbour readback of cleared table");

    stream(0, 0, -1, -1, latch_tab(), '0, 0, route_tab(), "R4 readback of routing table");

    // R9: latch made of both cells
    latch_step(1, 1, 1, "R9 follows D=1 with LOAD=1");
    latch_step(1, 0, 0, "R9 follows D=0 with LOAD=1");
    latch_step(1, 1, 1, "R9 follows D=1 again");
    latch_step(0, 1, 1, "R9 holds 1 after LOAD falls");
    latch_step(0, 0, 1, "R9 ignores D=0 while LOAD=0");
    latch_step(1, 0, 0, "R9 loads 0 when LOAD rises");
    latch_step(0, 0, 0, "R9 holds 0 after LOAD falls");
    latch_step(0, 1, 0, "R8 R9 ignores D=1 while LOAD=0 through neighbour buffer");

    // R1: reset again clears a configured table
    @(negedge clk);
    use_fb = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    eval_word(6'h15, 12'h000, "R1 table cleared by later reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule